// File: doc/BRIEF.md
# Dual-Accumulator Fixed-Point Multiply-Accumulate Engine

This block is the arithmetic core of a fixed-point signal-processing datapath. Each cycle it takes one opcode, two signed 16-bit operands and a select naming one of two 40-bit accumulators (A or B) as the destination. Operands are signed 1.15 fractions. A single signed multiplier forms the product. It is aligned to a 40-bit accumulator format with eight guard bits. One shared 40-bit adder/subtractor then combines it with the destination accumulator, with zero, or with the other accumulator. An optional clamp limits results to the signed 32-bit range, and each accumulator has its own sticky overflow flag.

While a multiply-accumulate, multiply-subtract, clear or keep operation runs, the engine can also return the accumulator that is not the destination. It rounds that value to a 16-bit word and saturates it, so surrounding logic can store it to memory in the same instruction slot. Three operations use the accumulators alone and ignore the operand inputs: sum of both, difference, and negate. Every result appears one clock after its opcode, together with a valid strobe.

Top module: `dsp_mac_engine`

## Requirements
- R1: The product is the signed 16x16 product shifted left by one and sign-extended to 40 bits; -32768 times -32768 yields exactly 0x0080000000 when saturation is off.
- R2: Product load (opcode 1) writes the product into the destination, negated load (2) writes its negation, and square load (3) writes the first operand times itself while the second operand is ignored.
- R3: Product accumulate (4) adds the product to the destination, product subtract (5) subtracts it, and square accumulate (6) adds the square of the first operand.
- R4: Clear (7) sets the destination to zero; keep (8) leaves both accumulators unchanged.
- R5: Sum (9) writes A+B to the destination; difference (10) writes destination minus the other accumulator; negate (11) writes the negation of the destination; the operand inputs have no effect on these three.
- R6: Only the accumulator chosen by the select (0 = A, 1 = B) can change in a cycle; the other keeps its value.
- R7: With saturation enabled, a result above 0x007FFFFFFF is stored as 0x007FFFFFFF and one below 0xFF80000000 as 0xFF80000000; with it disabled, the result wraps modulo 2^40.
- R8: Each accumulator's overflow flag is set when a result written to it falls outside the signed 32-bit range, whether or not saturation is on; it stays set until reset.
- R9: When write-back is requested during opcodes 4, 5, 7 or 8, the write-back valid goes high and the write-back data becomes bits [31:16] of the non-destination accumulator plus its bit 15, clamped to 0x7FFF..0x8000; for any other opcode the write-back valid stays low and the data holds its last value.
- R10: Opcodes 1 to 11 raise result valid one cycle later together with the new accumulator value; opcode 0 (idle) and opcodes 12 to 15 leave result valid low and change no state.
- R11: After reset both accumulators are zero, both flags are low, both valid outputs are low and the write-back data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_sel_i | input | 1 | Destination accumulator, 0 = A, 1 = B |
| opnd_x_i | input | 16 | First signed 1.15 operand |
| opnd_y_i | input | 16 | Second signed 1.15 operand |
| sat_en_i | input | 1 | Enable 32-bit saturation of results |
| wb_req_i | input | 1 | Request write-back of the non-destination accumulator |
| res_valid_o | output | 1 | Result of last cycle's operation is present |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| ovf_a_o | output | 1 | Sticky overflow flag of A |
| ovf_b_o | output | 1 | Sticky overflow flag of B |
| wb_valid_o | output | 1 | Write-back word is new this cycle |
| wb_data_o | output | 16 | Rounded, saturated write-back word |

## Verification
The hardest state to reach from the ports is a wrap through the guard bits. With saturation off, an accumulator has to climb past 2^39, and only repeated full-scale accumulations get it there. The stimulus therefore feeds 260 consecutive -1.0 times -1.0 accumulations into one accumulator. Write-back saturation likewise needs an accumulator parked at the 32-bit limit, so saturating accumulations pin A at each limit before it is read back through B-targeted operations. A long random phase then mixes all opcodes, selects and flags against a behavioural model checked every clock.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
  typedef enum logic [3:0] {
    OP_IDLE       = 4'd0,
    OP_MUL_LD     = 4'd1,
    OP_MUL_NEG_LD = 4'd2,
    OP_SQ_LD      = 4'd3,
    OP_MUL_ADD    = 4'd4,
    OP_MUL_SUB    = 4'd5,
    OP_SQ_ADD     = 4'd6,
    OP_ZERO       = 4'd7,
    OP_KEEP       = 4'd8,
    OP_SUM_AB     = 4'd9,
    OP_DIFF_AB    = 4'd10,
    OP_NEGATE     = 4'd11
  } dmac_op_e;
endpackage

// File: rtl/dmac_product.sv
`timescale 1ns/1ps
// Signed fractional multiplier: forms the product one bit wider than
// 2*OP_W so that -1.0 * -1.0 keeps its positive sign, then aligns it
// (shift by one) and sign-extends into the accumulator width.
module dmac_product #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [OP_W-1:0]  x_i,
  input  logic [OP_W-1:0]  y_i,
  output logic [ACC_W-1:0] prod_o
);
  localparam int PW = 2*OP_W + 1;

  logic signed [PW-1:0] x_ext;
  logic signed [PW-1:0] y_ext;
  logic signed [PW-1:0] p_full;

  assign x_ext  = {{(OP_W+1){x_i[OP_W-1]}}, x_i};
  assign y_ext  = {{(OP_W+1){y_i[OP_W-1]}}, y_i};
  assign p_full = x_ext * y_ext;

  // sign from the top product bit, magnitude bits moved up by one
  assign prod_o = {{(ACC_W-PW){p_full[PW-1]}}, p_full[PW-2:0], 1'b0};
endmodule

// File: rtl/dmac_addsat.sv
`timescale 1ns/1ps
// Shared adder/subtractor with one extra bit of headroom, range detect
// against the signed SAT_W-bit window and optional clamping.
module dmac_addsat #(
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input  logic [ACC_W-1:0] base_i,
  input  logic [ACC_W-1:0] addend_i,
  input  logic             sub_i,
  input  logic             sat_en_i,
  output logic [ACC_W-1:0] res_o,
  output logic             ovf_o
);
  localparam int SW = ACC_W + 1;
  localparam logic signed [SW-1:0] POS_LIM =
    {{(SW-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic signed [SW-1:0] NEG_LIM =
    {{(SW-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

  logic signed [SW-1:0] base_ext;
  logic signed [SW-1:0] add_ext;
  logic signed [SW-1:0] sum;
  logic                 above;
  logic                 below;

  assign base_ext = {base_i[ACC_W-1], base_i};
  assign add_ext  = {addend_i[ACC_W-1], addend_i};
  assign sum      = sub_i ? (base_ext - add_ext) : (base_ext + add_ext);
  assign above    = (sum > POS_LIM);
  assign below    = (sum < NEG_LIM);
  assign ovf_o    = above | below;

  always_comb begin
    if (sat_en_i && above)      res_o = POS_LIM[ACC_W-1:0];
    else if (sat_en_i && below) res_o = NEG_LIM[ACC_W-1:0];
    else                        res_o = sum[ACC_W-1:0];
  end
endmodule

// File: rtl/dmac_wb_round.sv
`timescale 1ns/1ps
// Write-back path: takes the accumulator from the rounding bit upward,
// adds the rounding bit to the high word and clamps to OP_W bits.
module dmac_wb_round #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:OP_W-1] acc_hi_i,
  output logic [OP_W-1:0]       wb_o
);
  localparam int HW = ACC_W - OP_W + 1;
  localparam logic signed [HW-1:0] MAX_W = {{(HW-OP_W+1){1'b0}}, {(OP_W-1){1'b1}}};
  localparam logic signed [HW-1:0] MIN_W = {{(HW-OP_W+1){1'b1}}, {(OP_W-1){1'b0}}};

  logic signed [HW-1:0] hi_word;
  logic signed [HW-1:0] rnd_inc;
  logic signed [HW-1:0] rounded;

  assign hi_word = {acc_hi_i[ACC_W-1], acc_hi_i[ACC_W-1:OP_W]};
  assign rnd_inc = {{(HW-1){1'b0}}, acc_hi_i[OP_W-1]};
  assign rounded = hi_word + rnd_inc;

  always_comb begin
    if (rounded > MAX_W)      wb_o = MAX_W[OP_W-1:0];
    else if (rounded < MIN_W) wb_o = MIN_W[OP_W-1:0];
    else                      wb_o = rounded[OP_W-1:0];
  end
endmodule

// File: rtl/dsp_mac_engine.sv
`timescale 1ns/1ps
module dsp_mac_engine
  import dmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_i,
  input  logic             acc_sel_i,
  input  logic [OP_W-1:0]  opnd_x_i,
  input  logic [OP_W-1:0]  opnd_y_i,
  input  logic             sat_en_i,
  input  logic             wb_req_i,
  output logic             res_valid_o,
  output logic [ACC_W-1:0] acc_a_o,
  output logic [ACC_W-1:0] acc_b_o,
  output logic             ovf_a_o,
  output logic             ovf_b_o,
  output logic             wb_valid_o,
  output logic [OP_W-1:0]  wb_data_o
);
  // ---------------- reset: asserted asynchronously, released on clk
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  // ---------------- state
  logic [ACC_W-1:0] acc_a_q, acc_b_q;
  logic             ovf_a_q, ovf_b_q;
  logic             res_valid_q, wb_valid_q;
  logic [OP_W-1:0]  wb_data_q;

  // ---------------- datapath
  dmac_op_e         op;
  logic             sq_sel;
  logic [OP_W-1:0]  mul_y;
  logic [ACC_W-1:0] prod;
  logic [ACC_W-1:0] tgt_val, oth_val;
  logic [ACC_W-1:0] base, addend, sum_res;
  logic             sub, wr, wb_ok, known, sum_ovf;
  logic [OP_W-1:0]  wb_rnd;

  assign op      = dmac_op_e'(op_i);
  assign sq_sel  = (op == OP_SQ_LD) || (op == OP_SQ_ADD);
  assign mul_y   = sq_sel ? opnd_x_i : opnd_y_i;
  assign tgt_val = acc_sel_i ? acc_b_q : acc_a_q;
  assign oth_val = acc_sel_i ? acc_a_q : acc_b_q;

  dmac_product #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
    .x_i   (opnd_x_i),
    .y_i   (mul_y),
    .prod_o(prod)
  );

  always_comb begin
    base   = '0;
    addend = '0;
    sub    = 1'b0;
    wr     = 1'b0;
    wb_ok  = 1'b0;
    known  = 1'b1;
    case (op)
      OP_MUL_LD:     begin addend = prod; wr = 1'b1; end
      OP_MUL_NEG_LD: begin addend = prod; sub = 1'b1; wr = 1'b1; end
      OP_SQ_LD:      begin addend = prod; wr = 1'b1; end
      OP_MUL_ADD:    begin base = tgt_val; addend = prod; wr = 1'b1; wb_ok = 1'b1; end
      OP_MUL_SUB:    begin base = tgt_val; addend = prod; sub = 1'b1; wr = 1'b1; wb_ok = 1'b1; end
      OP_SQ_ADD:     begin base = tgt_val; addend = prod; wr = 1'b1; end
      OP_ZERO:       begin wr = 1'b1; wb_ok = 1'b1; end
      OP_KEEP:       begin wb_ok = 1'b1; end
      OP_SUM_AB:     begin base = tgt_val; addend = oth_val; wr = 1'b1; end
      OP_DIFF_AB:    begin base = tgt_val; addend = oth_val; sub = 1'b1; wr = 1'b1; end
      OP_NEGATE:     begin addend = tgt_val; sub = 1'b1; wr = 1'b1; end
      default:       known = 1'b0;
    endcase
  end

  dmac_addsat #(.ACC_W(ACC_W), .SAT_W(SAT_W)) u_addsat (
    .base_i  (base),
    .addend_i(addend),
    .sub_i   (sub),
    .sat_en_i(sat_en_i),
    .res_o   (sum_res),
    .ovf_o   (sum_ovf)
  );

  dmac_wb_round #(.OP_W(OP_W), .ACC_W(ACC_W)) u_wb (
    .acc_hi_i(oth_val[ACC_W-1:OP_W-1]),
    .wb_o    (wb_rnd)
  );

  // ---------------- next state and enables
  logic acc_a_en, acc_b_en, wb_fire;
  logic ovf_a_d, ovf_b_d;

  always_comb begin
    acc_a_en = wr & ~acc_sel_i;
    acc_b_en = wr &  acc_sel_i;
    wb_fire  = wb_ok & wb_req_i;
    ovf_a_d  = ovf_a_q | (acc_a_en & sum_ovf);
    ovf_b_d  = ovf_b_q | (acc_b_en & sum_ovf);
  end

  // ---------------- registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      acc_a_q     <= '0;
      acc_b_q     <= '0;
      ovf_a_q     <= 1'b0;
      ovf_b_q     <= 1'b0;
      res_valid_q <= 1'b0;
      wb_valid_q  <= 1'b0;
      wb_data_q   <= '0;
    end else begin
      if (acc_a_en) acc_a_q   <= sum_res;
      if (acc_b_en) acc_b_q   <= sum_res;
      if (wb_fire)  wb_data_q <= wb_rnd;
      ovf_a_q     <= ovf_a_d;
      ovf_b_q     <= ovf_b_d;
      res_valid_q <= known;
      wb_valid_q  <= wb_fire;
    end
  end

  assign acc_a_o     = acc_a_q;
  assign acc_b_o     = acc_b_q;
  assign ovf_a_o     = ovf_a_q;
  assign ovf_b_o     = ovf_b_q;
  assign res_valid_o = res_valid_q;
  assign wb_valid_o  = wb_valid_q;
  assign wb_data_o   = wb_data_q;

  // ---------------- assertions
  function automatic logic fits_sat(input logic [ACC_W-1:0] v);
    return (&v[ACC_W-1:SAT_W-1]) | ~(|v[ACC_W-1:SAT_W-1]);
  endfunction

  p_valid_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (op_i inside {[4'd1:4'd11]}) |=> res_valid_o);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    !(op_i inside {[4'd1:4'd11]}) |=> (!res_valid_o && $stable(acc_a_o) && $stable(acc_b_o)));

  p_hold_b_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (!acc_sel_i) |=> $stable(acc_b_o));

  p_hold_a_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (acc_sel_i) |=> $stable(acc_a_o));

  p_clear_a_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (op_i == OP_ZERO && !acc_sel_i) |=> (acc_a_o == '0));

  p_keep_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (op_i == OP_KEEP) |=> ($stable(acc_a_o) && $stable(acc_b_o)));

  p_sat_a_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (sat_en_i && !acc_sel_i && (op_i inside {[4'd1:4'd7], [4'd9:4'd11]}))
      |=> fits_sat(acc_a_o));

  p_sat_b_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (sat_en_i && acc_sel_i && (op_i inside {[4'd1:4'd7], [4'd9:4'd11]}))
      |=> fits_sat(acc_b_o));

  p_ovf_a_sticky_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    ovf_a_o |=> ovf_a_o);

  p_ovf_b_sticky_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    ovf_b_o |=> ovf_b_o);

  p_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    !(op_i inside {4'd4, 4'd5, 4'd7, 4'd8}) |=> (!wb_valid_o && $stable(wb_data_o)));
endmodule

// File: tb/sim_dsp_mac_engine.sv
`timescale 1ns/1ps
module sim_dsp_mac_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op_i;
  logic        acc_sel_i;
  logic [15:0] opnd_x_i, opnd_y_i;
  logic        sat_en_i, wb_req_i;
  logic        res_valid_o;
  logic [39:0] acc_a_o, acc_b_o;
  logic        ovf_a_o, ovf_b_o;
  logic        wb_valid_o;
  logic [15:0] wb_data_o;

  dsp_mac_engine u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_sel_i(acc_sel_i),
    .opnd_x_i(opnd_x_i), .opnd_y_i(opnd_y_i), .sat_en_i(sat_en_i),
    .wb_req_i(wb_req_i), .res_valid_o(res_valid_o), .acc_a_o(acc_a_o),
    .acc_b_o(acc_b_o), .ovf_a_o(ovf_a_o), .ovf_b_o(ovf_b_o),
    .wb_valid_o(wb_valid_o), .wb_data_o(wb_data_o)
  );

  always #4 clk = ~clk;  // 125 MHz

  localparam longint M40  = (64'sd1 <<< 40) - 1;
  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference state
  longint ea = 0, eb = 0, ewd = 0;
  bit ova = 0, ovb = 0, erv = 0, ewv = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk(req, "acc_a", longint'(acc_a_o), ea & M40);
    chk(req, "acc_b", longint'(acc_b_o), eb & M40);
    chk(req, "ovf_a", longint'(ovf_a_o), longint'(ova));
    chk(req, "ovf_b", longint'(ovf_b_o), longint'(ovb));
    chk(req, "res_valid", longint'(res_valid_o), longint'(erv));
    chk(req, "wb_valid", longint'(wb_valid_o), longint'(ewv));
    chk(req, "wb_data", longint'(wb_data_o), ewd & 64'hFFFF);
  endtask

  // called just after a falling edge; drives, updates model, checks at next falling edge
  task automatic do_op(input int op, input bit sel, input int x, input int y,
                       input bit sat, input bit wb, input string req);
    longint t, o, p, r, h;
    bit w, ov;
    op_i      = 4'(op);
    acc_sel_i = sel;
    opnd_x_i  = 16'(x);
    opnd_y_i  = 16'(y);
    sat_en_i  = sat;
    wb_req_i  = wb;
    p = longint'(x) * longint'((op == 3 || op == 6) ? x : y) * 2;
    t = sel ? eb : ea;
    o = sel ? ea : eb;
    r = 0;
    w = 1'b1;
    case (op)
      1: r = p;
      2: r = -p;
      3: r = p;
      4: r = t + p;
      5: r = t - p;
      6: r = t + p;
      7: r = 0;
      9: r = t + o;
      10: r = t - o;
      11: r = -t;
      default: w = 1'b0;
    endcase
    erv = (op >= 1 && op <= 11);
    ewv = wb && (op == 4 || op == 5 || op == 7 || op == 8);
    if (ewv) begin
      h = (o >>> 16) + ((o >>> 15) & 1);
      if (h > 32767) h = 32767;
      if (h < -32768) h = -32768;
      ewd = h & 64'hFFFF;
    end
    if (w) begin
      ov = (r > SMAX) || (r < SMIN);
      if (sat) begin
        if (r > SMAX) r = SMAX;
        if (r < SMIN) r = SMIN;
      end else begin
        r = (r <<< 24) >>> 24;
      end
      if (sel) begin eb = r; ovb = ovb | ov; end
      else     begin ea = r; ova = ova | ov; end
    end
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_i = '0; acc_sel_i = 1'b0; opnd_x_i = '0; opnd_y_i = '0;
    sat_en_i = 1'b0; wb_req_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_all("R11");

    // R1 product alignment, including -1.0 * -1.0
    do_op(1, 0, -32768, -32768, 0, 0, "R1");
    do_op(1, 1, 16384, 16384, 0, 0, "R1");
    // R2 loads
    do_op(2, 1, 16384, -8192, 0, 0, "R2");
    do_op(3, 0, -12345, 999, 0, 0, "R2");
    do_op(3, 1, 300, -7, 0, 0, "R2");
    // R3 accumulate family, with write-back of the other accumulator
    do_op(4, 0, 1000, -2000, 0, 1, "R3");
    do_op(5, 0, -3000, 77, 0, 1, "R3");
    do_op(6, 1, -20000, 5, 0, 0, "R3");
    // R4 keep and clear
    do_op(8, 0, 777, 888, 0, 1, "R4");
    do_op(7, 1, 5, 5, 0, 1, "R4");
    // R5 inherent operations with operands that must be ignored
    do_op(1, 1, 12000, -9000, 0, 0, "R5");
    do_op(9, 1, 1234, -4321, 0, 0, "R5");
    do_op(10, 0, -1, 32767, 0, 0, "R5");
    do_op(11, 0, 555, 666, 0, 0, "R5");
    do_op(11, 1, -32768, -32768, 1, 0, "R5");
    // R6 destination B only
    do_op(4, 1, 321, 123, 0, 0, "R6");
    // R7 positive and negative clamping
    do_op(7, 0, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 4; i++) do_op(4, 0, -32768, -32768, 1, 0, "R7");
    for (int i = 0; i < 5; i++) do_op(5, 0, 32767, 32767, 1, 0, "R7");
    // R9 write-back from A at negative limit, then positive limit
    do_op(8, 1, 0, 0, 0, 1, "R9");
    do_op(7, 0, 0, 0, 0, 0, "R9");
    do_op(4, 0, -32768, -32768, 1, 0, "R9");
    do_op(4, 1, 1, 1, 0, 1, "R9");
    do_op(1, 0, 16384, 3, 0, 0, "R9");
    do_op(5, 1, 2, 2, 0, 1, "R9");
    do_op(1, 1, 3, 3, 0, 1, "R9");
    do_op(10, 1, 3, 3, 0, 1, "R9");
    // R7 guard-bit wrap with saturation off, R8 flag on B
    do_op(7, 1, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 260; i++) do_op(4, 1, -32768, -32768, 0, 0, "R7");
    do_op(7, 1, 0, 0, 0, 0, "R8");
    do_op(7, 0, 0, 0, 1, 0, "R8");
    // R10 idle and undefined opcodes
    do_op(0, 0, 1111, 2222, 1, 1, "R10");
    do_op(13, 1, 1111, 2222, 1, 1, "R10");
    do_op(15, 0, -5, 5, 0, 1, "R10");
    // random mix
    for (int i = 0; i < 600; i++) begin
      do_op(int'($urandom_range(0, 13)), 1'($urandom_range(0, 1)),
            int'($urandom_range(0, 65535)) - 32768,
            int'($urandom_range(0, 65535)) - 32768,
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R6");
    end
    do_op(0, 0, 0, 0, 0, 0, "R10");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule